// File: doc/BRIEF.md
# Late-Write Flowthrough Synchronous Static Memory

This block is a synchronous static memory with a flowthrough read path and a delayed write data phase. A command (load or advance, read or write), an address, three chip selects and two active-low byte write enables are captured on a rising clock edge. A read returns its word in the clock period right after that edge. A write takes its data one edge later. Because both kinds of command use the data bus in the same slot, reads and writes can follow each other in any order with no idle bus cycle.

A load cycle starts a new operation. An advance cycle continues the current burst of up to four words. The two low address bits step either in interleaved order (base XOR count) or in linear order (base plus count, modulo four). An active-low clock enable freezes the whole block for a cycle. An active-low output enable gates the drivers asynchronously. The data bus is split into an input, an output and a drive-enable, so the block can sit behind a pad ring or an on-chip tri-state buffer. The default array is 1024 words of two 9-bit bytes.

Top module: `sram_late_write_ft`

## Requirements
- R1: After reset, including a reset that arrives between a write command and its data edge, the bus is not driven, the burst state is deselect, and no pending write reaches the array.
- R2: With the chip selected and output enable low, a read command drives the addressed word on dq_o with dq_oe_o high during the clock period right after the command edge.
- R3: Write data on dq_i is captured on the first enabled edge after the write command and stored at the command's address. During that data slot dq_oe_o stays low, even with oe_ni low.
- R4: The chip counts as selected only when sel0_ni=0, sel1_i=1 and sel2_ni=0. A load with any other combination is a deselect with the bus not driven, and later advance cycles continue the deselect.
- R5: On an advance cycle (load_ni=1), addr_i, the three selects and rd_wr_i are ignored. The burst keeps the operation type chosen at its load (rd_wr_i=1 read, 0 write).
- R6: During a burst only the two low address bits change. For advance number k (1 to 3, wrapping to the base after four words), they are base XOR k when lin_burst_i=0 and base+k modulo 4 when lin_burst_i=1.
- R7: bw_ni[0]=0 enables bits 8:0 and bw_ni[1]=0 enables bits 17:9. The enables are sampled with each write or burst-write command. With both enables high the write is aborted and the word is unchanged.
- R8: With cen_ni=1 no state changes and no write is done. A read in its data slot keeps driving the same word, and a write's data slot stays undriven. A pending write completes on the next enabled edge with the data then on dq_i.
- R9: oe_ni=1 keeps the bus undriven. A read loaded with oe_ni=1 (dummy read) still sets up the burst, so a later advance with oe_ni=0 drives the next burst word.
- R10: A read loaded on the data edge of a write to the same address returns the newly written word. Alternating write and read commands need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; high freezes the block |
| load_ni | input | 1 | Low loads a new command, high advances the burst |
| rd_wr_i | input | 1 | Command type on load: 1 read, 0 write |
| sel0_ni | input | 1 | Chip select, active low |
| sel1_i | input | 1 | Chip select, active high |
| sel2_ni | input | 1 | Chip select, active low |
| lin_burst_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| bw_ni | input | 2 | Byte write enables, active low, bit 0 for bits 8:0 |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | 10 | Word address, sampled on load cycles |
| dq_i | input | 18 | Write data, captured one edge after the write command |
| dq_o | output | 18 | Read data |
| dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The critical overlap is a write's data edge falling on the same edge as the next command's load. A late write to an address commits on exactly the edge where a read of that address is captured. The bench provokes this with back-to-back write-then-read pairs and with random streams that mix loads, advances, stalls, aborts and dummy reads. It judges each cycle's drive enable and data against a reference array and burst model kept in the bench. A clock-enable stall placed on a pending write's data edge checks that the commit moves to the next enabled edge and takes the data present then.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_lw_ctl.sv
module sram_lw_ctl
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BYTES = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 load_ni,
  input  logic                 rd_wr_i,
  input  logic                 sel0_ni,
  input  logic                 sel1_i,
  input  logic                 sel2_ni,
  input  logic                 lin_burst_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_BYTES-1:0] bw_ni,
  output op_e                  op_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [NUM_BYTES-1:0] bw_no
);
  localparam int CW = $clog2(BURST_LEN);

  op_e                  op_q, burst_op_q;
  logic [ADDR_W-1:0]    base_q, addr_q;
  logic [CW-1:0]        cnt_q, cnt_nxt;
  logic [NUM_BYTES-1:0] bw_q;
  logic                 sel_ok;
  op_e                  load_op;

  function automatic logic [CW-1:0] seq_low(logic [CW-1:0] b, logic [CW-1:0] c, logic lin);
    return lin ? b + c : b ^ c;
  endfunction

  assign sel_ok  = !sel0_ni && sel1_i && !sel2_ni;
  assign load_op = !sel_ok ? OP_NONE : (rd_wr_i ? OP_READ : OP_WRITE);
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_NONE;
      burst_op_q <= OP_NONE;
      base_q     <= '0;
      addr_q     <= '0;
      cnt_q      <= '0;
      bw_q       <= '1;
    end else if (en_i) begin
      bw_q <= bw_ni;
      if (!load_ni) begin
        burst_op_q <= load_op;
        op_q       <= load_op;
        base_q     <= addr_i;
        addr_q     <= addr_i;
        cnt_q      <= '0;
      end else begin
        // continue: type fixed at load, low bits follow burst order
        op_q   <= burst_op_q;
        cnt_q  <= cnt_nxt;
        addr_q <= {base_q[ADDR_W-1:CW], seq_low(base_q[CW-1:0], cnt_nxt, lin_burst_i)};
      end
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign bw_no  = bw_q;

  AST_STALL_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(op_q) && $stable(addr_q) && $stable(cnt_q) && $stable(bw_q)); // R8
  AST_ADV_KEEPS_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_ni |=> op_q == $past(op_q)); // R5
  AST_BURST_HIGH_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_ni |=> addr_q[ADDR_W-1:CW] == $past(addr_q[ADDR_W-1:CW])); // R6
  AST_DESEL_ON_SEL1_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_ni && !sel1_i |=> op_q == OP_NONE); // R4
endmodule

// File: rtl/sram_lw_array.sv
module sram_lw_array #(
  parameter int ADDR_W    = 10,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [NUM_BYTES-1:0]        wmask_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[b]) mem[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
    // flowthrough: read is combinational from the registered address
    assign rdata_o[b*BYTE_W +: BYTE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_late_write_ft.sv
module sram_late_write_ft
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cen_ni,
  input  logic                        load_ni,
  input  logic                        rd_wr_i,
  input  logic                        sel0_ni,
  input  logic                        sel1_i,
  input  logic                        sel2_ni,
  input  logic                        lin_burst_i,
  input  logic [NUM_BYTES-1:0]        bw_ni,
  input  logic                        oe_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] dq_i,
  output logic [NUM_BYTES*BYTE_W-1:0] dq_o,
  output logic                        dq_oe_o
);
  localparam int DATA_W = NUM_BYTES * BYTE_W;

  op_e                  ph_op;
  logic [ADDR_W-1:0]    ph_addr;
  logic [NUM_BYTES-1:0] ph_bw_n;
  logic [DATA_W-1:0]    rdata;
  logic                 en, wr_commit;

  assign en = !cen_ni;

  sram_lw_ctl #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BURST_LEN(BURST_LEN)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .load_ni(load_ni), .rd_wr_i(rd_wr_i),
    .sel0_ni(sel0_ni), .sel1_i(sel1_i), .sel2_ni(sel2_ni), .lin_burst_i(lin_burst_i),
    .addr_i(addr_i), .bw_ni(bw_ni), .op_o(ph_op), .addr_o(ph_addr), .bw_no(ph_bw_n)
  );

  // late write: data slot is the cycle after the command, commit on the next enabled edge
  assign wr_commit = en && (ph_op == OP_WRITE);

  sram_lw_array #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)
  ) u_array (
    .clk_i(clk_i), .we_i(wr_commit), .wmask_i(~ph_bw_n), .addr_i(ph_addr),
    .wdata_i(dq_i), .rdata_o(rdata)
  );

  assign dq_o    = (ph_op == OP_READ) ? rdata : '0;
  assign dq_oe_o = (ph_op == OP_READ) && !oe_ni;

  AST_WRITE_SLOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_op == OP_WRITE |-> !dq_oe_o); // R3
  AST_OE_GATES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o); // R9
  AST_STALLED_READ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni && ph_op == OP_READ |=> $stable(dq_o)); // R8
endmodule

// File: tb/sram_late_write_ft_test.sv
module sram_late_write_ft_test;
  logic        clk = 0, rst_n = 0;
  logic        cen_n = 0, ld_n = 1, rd = 1, s0_n = 1, s1 = 0, s2_n = 1, lin = 0, oe_n = 0;
  logic [1:0]  bw_n = 2'b11;
  logic [9:0]  addr = '0;
  logic [17:0] din = '0, dq;
  logic        dq_oe;
  int total = 0, bad = 0;
  bit done = 0;

  sram_late_write_ft uut (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(cen_n), .load_ni(ld_n), .rd_wr_i(rd),
    .sel0_ni(s0_n), .sel1_i(s1), .sel2_ni(s2_n), .lin_burst_i(lin), .bw_ni(bw_n),
    .oe_ni(oe_n), .addr_i(addr), .dq_i(din), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  always #10 clk = ~clk;

  // reference model
  logic [17:0] ref_mem [1024];
  int          m_ph = 0, m_bop = 0;   // 0 none, 1 read, 2 write
  logic [9:0]  m_addr = '0, m_base = '0;
  logic [1:0]  m_cnt = '0, m_bw = 2'b11;

  task automatic model_reset();
    m_ph = 0; m_bop = 0; m_cnt = '0; m_bw = 2'b11;
  endtask

  task automatic model_edge();
    logic [1:0] lo;
    if (!cen_n) begin
      if (m_ph == 2) begin
        if (!m_bw[0]) ref_mem[m_addr][8:0]  = din[8:0];
        if (!m_bw[1]) ref_mem[m_addr][17:9] = din[17:9];
      end
      if (!ld_n) begin
        m_bop  = (!s0_n && s1 && !s2_n) ? (rd ? 1 : 2) : 0;
        m_base = addr; m_cnt = '0; m_addr = addr;
      end else begin
        m_cnt  = m_cnt + 1'b1;
        lo     = lin ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
        m_addr = {m_base[9:2], lo};
      end
      m_ph = m_bop; m_bw = bw_n;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #2;
  endtask

  task automatic check(input bit ok, input int r, input logic [18:0] act, input logic [18:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic set_sel(input bit good);
    s0_n = 0; s1 = 1; s2_n = 0;
    if (!good) case ($urandom % 3)
      0: s0_n = 1;
      1: s1 = 0;
      default: s2_n = 1;
    endcase
  endtask

  task automatic model_check(input int r);
    logic        e_oe;
    logic [17:0] e_dq;
    e_oe = (m_ph == 1) && !oe_n;
    e_dq = e_oe ? ref_mem[m_addr] : 18'h0;
    check(dq_oe === e_oe && (!e_oe || dq === e_dq), r, {dq_oe, dq}, {e_oe, e_dq});
  endtask

  task automatic do_reset();
    rst_n = 0; #25; rst_n = 1; model_reset();
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        ld_n, rd, sel, cen_n, oe_n;
    logic [1:0]  bw_n;
    logic [9:0]  addr;
    logic [17:0] din;
    logic        exp_oe;
    logic [17:0] exp_dq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,10'h010,18'h00000,1'b0,18'h00000,4'd3},  // R3 write 0x010
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,10'h011,18'h12345,1'b0,18'h00000,4'd3},  // R3 data for 0x010
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,10'h010,18'h0ABCD,1'b1,18'h12345,4'd10}, // R10 R2
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,10'h011,18'h00000,1'b1,18'h0ABCD,4'd2},  // R2
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b10,10'h010,18'h00000,1'b0,18'h00000,4'd3},  // low byte only
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,10'h010,18'h3FFFF,1'b1,18'h123FF,4'd7},  // R7
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b11,10'h011,18'h00000,1'b0,18'h00000,4'd7},  // abort
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,10'h011,18'h00000,1'b1,18'h0ABCD,4'd7},  // R7 unchanged
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b01,10'h011,18'h00000,1'b0,18'h00000,4'd7},  // high byte only
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,10'h011,18'h3FFFF,1'b1,18'h3FFCD,4'd7},  // R7
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,10'h010,18'h00000,1'b0,18'h00000,4'd4},  // R4 deselect
    '{1'b1,1'b1,1'b1,1'b0,1'b0,2'b00,10'h011,18'h00000,1'b0,18'h00000,4'd4},  // R4 continue deselect
    '{1'b0,1'b1,1'b1,1'b0,1'b1,2'b00,10'h010,18'h00000,1'b0,18'h00000,4'd9},  // R9 dummy read
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b11,10'h3FF,18'h00000,1'b1,18'h3FFCD,4'd5},  // R5 R6 R9 advance -> 0x011
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,10'h000,18'h00000,1'b1,18'h3FFCD,4'd8},  // R8 stalled read holds
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,10'h011,18'h00000,1'b0,18'h00000,4'd3},  // write 0x011
    '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,10'h000,18'h00001,1'b0,18'h00000,4'd8},  // R8 stalled write slot
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,10'h011,18'h15555,1'b1,18'h15555,4'd8}   // R8 commit on next edge
  };

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] saved;
    // R1: reset state
    #5;
    check(dq_oe === 1'b0, 1, {dq_oe, dq}, 19'h0);
    do_reset();
    tick();
    check(dq_oe === 1'b0, 1, {dq_oe, dq}, 19'h0);

    for (int i = 0; i < NV; i++) begin
      ld_n = VECS[i].ld_n; rd = VECS[i].rd; cen_n = VECS[i].cen_n; oe_n = VECS[i].oe_n;
      bw_n = VECS[i].bw_n; addr = VECS[i].addr; din = VECS[i].din; lin = 1'b0;
      s0_n = 0; s1 = VECS[i].sel; s2_n = 0;
      tick();
      check(dq_oe === VECS[i].exp_oe && (!VECS[i].exp_oe || dq === VECS[i].exp_dq),
            int'(VECS[i].req), {dq_oe, dq}, {VECS[i].exp_oe, VECS[i].exp_dq});
    end

    // preload a 32-word window through the model
    do_reset();
    cen_n = 0; oe_n = 0; lin = 0; bw_n = 2'b00; set_sel(1);
    for (int i = 0; i < 33; i++) begin
      ld_n = 0; rd = (i == 32); din = 18'($urandom);
      addr = {(i[4] ? 6'h3F : 6'h00), i[3:0]};
      tick();
    end

    // R6: explicit burst orders from base 1
    for (int m = 0; m < 2; m++) begin
      int exp_lo [5];
      exp_lo = (m == 0) ? '{1, 0, 3, 2, 1} : '{1, 2, 3, 0, 1};
      lin = m[0]; ld_n = 0; rd = 1; set_sel(1); addr = 10'h001; bw_n = 2'b11;
      tick();
      for (int k = 0; k < 5; k++) begin
        if (k > 0) begin ld_n = 1; tick(); end
        check(dq_oe === 1'b1 && dq === ref_mem[exp_lo[k]], 6, {dq_oe, dq}, {1'b1, ref_mem[exp_lo[k]]});
      end
    end

    // random interleaved stream: R2 R3 R5 R6 R7 R8 R9 R10
    for (int n = 0; n < 3000; n++) begin
      cen_n = ($urandom % 8) == 0;
      ld_n  = ($urandom % 2) == 0;
      rd    = $urandom % 2;
      set_sel(($urandom % 7) != 0);
      bw_n  = 2'($urandom);
      oe_n  = ($urandom % 7) == 0;
      if (!ld_n) lin = $urandom % 2;
      addr  = {(($urandom % 2) ? 6'h3F : 6'h00), 4'($urandom)};
      din   = 18'($urandom);
      tick();
      model_check(10);
    end

    // R1: reset between write command and its data edge drops the write
    cen_n = 0; oe_n = 0; set_sel(1); ld_n = 0; rd = 0; bw_n = 2'b00; addr = 10'h005;
    tick();
    saved = ref_mem[5];
    do_reset();
    ld_n = 1; din = ~saved;
    tick();
    ld_n = 0; rd = 1; set_sel(1); addr = 10'h005;
    tick();
    check(dq_oe === 1'b1 && dq === saved, 1, {dq_oe, dq}, {1'b1, saved});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule